// File: doc/BRIEF.md
# Chunky-to-Planar Register Port

This block is a bus peripheral that turns packed pixels into bitplanes behind one data register. The host writes eight 32-bit words of packed 8-bit pixels (four pixels per word, 32 pixels in all) to the data address. The eighth write starts a short conversion phase in which the 32x8 bit matrix is transposed. The host then reads eight 32-bit words back from the same address, each holding one bitplane for all 32 pixels. After the last read the port is ready for the next group.

A read that arrives while the transpose is still running holds the bus wait line until the result exists, so a host may start reading at once after its eighth write. A write that arrives during the read-out phase abandons the remaining planar words and becomes the first word of a new group. Accesses to any other address leave the port untouched.

Top module: `c2p_regport`

## Requirements
- R1: After a synchronous active-low reset the port is collecting with both counters at zero, `bus_wait` is 0 and `bus_rdata` is 0.
- R2: Writes to the data address (`bus_addr == DATA_ADDR`) while collecting are stored in order as chunky words 0 to 7; the eighth write starts the conversion.
- R3: Pixel k (0 to 31) is byte k mod 4 of chunky word k/4, with byte 0 in bits 31:24 and byte 3 in bits 7:0. In the planar word for plane n, bit 31-k equals bit n of pixel k.
- R4: Reads during read-out return plane 0 first and plane 7 last, one plane per read; after the eighth read the port is collecting again.
- R5: A read to the data address during conversion drives `bus_wait` high with `bus_rdata` 0; conversion lasts `CONV_LAT` cycles (default 2), and the read completes with data in the first read-out cycle.
- R6: A write to the data address during read-out drops the remaining planes, is stored as chunky word 0, and the next seven writes complete the new group.
- R7: Writes during conversion are ignored and do not change the result.
- R8: Accesses to any address other than `DATA_ADDR` neither store data nor advance a counter; such reads return 0 without wait.
- R9: A read to the data address while collecting returns 0, does not wait and does not change the collection count.
- R10: Reset in the middle of a group discards it; the next eight writes form a fresh group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register address |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle when wait is low |
| bus_wait | output | 1 | Holds the current read until data is ready |

## Verification
The bench drives a reference model of the three phases alongside the port and goes after the boundaries between them. A read issued on the cycle after the eighth write must stall for exactly the conversion time; a design that released it early would return the previous group's planes. A write during read-out must restart at word 0; an off-by-one there shifts every pixel by four positions. Stray writes during conversion, accesses to other addresses and a reset mid-group all must leave no trace, which a single-pixel pattern exposes as a wrong plane or a shifted bit.

// File: rtl/c2p_pkg.sv
// Shared types for the chunky-to-planar register port.
// Assumes: no parameters of its own; widths live in the modules.
package c2p_pkg;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_CONVERT = 2'd1,
        ST_DRAIN   = 2'd2
    } c2p_phase_e;

endpackage

// File: rtl/c2p_chunk_buf.sv
// Holds the chunky input words written by the host.
// Assumes: at most one write per cycle; idx is always below DEPTH.
module c2p_chunk_buf #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W-1:0]          idx,
    input  logic [WORD_W-1:0]         wdata,
    output logic [DEPTH*WORD_W-1:0]   flat
);

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [WORD_W-1:0] word_q;

        // Store the word when its slot is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (we && idx == IDX_W'(s))
                word_q <= wdata;
        end

        assign flat[s*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/c2p_transpose.sv
// Transposes PIX_W chunky words into PIX_W planar words and registers them.
// Pixel k sits in word k/PPW at byte k%PPW counted from the MSB end;
// plane n holds bit n of pixel k at bit WORD_W-1-k.
// Assumes: WORD_W == PIX_W * PIX_W / (PIX_W) * PPW, i.e. PIX_W*PPW == WORD_W.
module c2p_transpose #(
    parameter int WORD_W = 32,
    parameter int PIX_W  = 8,
    localparam int PPW   = WORD_W / PIX_W,
    localparam int NPIX  = PIX_W * PPW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap,
    input  logic [PIX_W*WORD_W-1:0]   chunky,
    output logic [PIX_W*WORD_W-1:0]   planar
);

    logic [PIX_W*WORD_W-1:0] swapped;

    for (genvar n = 0; n < PIX_W; n++) begin : g_plane
        for (genvar k = 0; k < NPIX; k++) begin : g_pix
            assign swapped[n*WORD_W + (WORD_W-1-k)] =
                chunky[(k/PPW)*WORD_W + WORD_W - PIX_W*((k%PPW)+1) + n];
        end
    end

    // Latch the transposed group at the end of conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            planar <= '0;
        else if (cap)
            planar <= swapped;
    end

endmodule

// File: rtl/c2p_seq.sv
// Phase sequencer: counts writes while collecting, times the conversion,
// counts reads while draining. A write while draining restarts collection.
// Assumes: wr_hit and rd_hit are already qualified by the address match.
module c2p_seq
    import c2p_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int CONV_LAT = 2,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(CONV_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             rd_hit,
    output c2p_phase_e       phase,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic             slot_we,
    output logic [IDX_W-1:0] slot_idx,
    output logic             cap
);

    logic [CNT_W-1:0] conv_cnt;
    logic             last_wr;
    logic             last_rd;

    assign last_wr  = (wr_idx == IDX_W'(DEPTH-1));
    assign last_rd  = (rd_idx == IDX_W'(DEPTH-1));
    assign cap      = (phase == ST_CONVERT) && (conv_cnt == '0);
    assign slot_we  = wr_hit && (phase != ST_CONVERT);
    assign slot_idx = (phase == ST_DRAIN) ? '0 : wr_idx;

    // Advance phase and counters on bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= ST_COLLECT;
            wr_idx   <= '0;
            rd_idx   <= '0;
            conv_cnt <= '0;
        end else begin
            case (phase)
                ST_COLLECT: begin
                    if (wr_hit) begin
                        if (last_wr) begin
                            phase    <= ST_CONVERT;
                            wr_idx   <= '0;
                            conv_cnt <= CNT_W'(CONV_LAT - 1);
                        end else begin
                            wr_idx <= wr_idx + 1'b1;
                        end
                    end
                end
                ST_CONVERT: begin
                    if (conv_cnt == '0) begin
                        phase  <= ST_DRAIN;
                        rd_idx <= '0;
                    end else begin
                        conv_cnt <= conv_cnt - 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (wr_hit) begin
                        phase  <= ST_COLLECT;
                        wr_idx <= IDX_W'(1);
                        rd_idx <= '0;
                    end else if (rd_hit) begin
                        if (last_rd) begin
                            phase  <= ST_COLLECT;
                            rd_idx <= '0;
                        end else begin
                            rd_idx <= rd_idx + 1'b1;
                        end
                    end
                end
                default: phase <= ST_COLLECT;
            endcase
        end
    end

    // R2: eighth write enters conversion
    p_full_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_COLLECT && wr_hit && last_wr) |=> (phase == ST_CONVERT));

    // R4: eighth read returns to collection with an empty count
    p_drain_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_DRAIN && !wr_hit && rd_hit && last_rd)
        |=> (phase == ST_COLLECT && wr_idx == '0));

    // R6: write during read-out restarts with one word held
    p_abort_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_DRAIN && wr_hit) |=> (phase == ST_COLLECT && wr_idx == IDX_W'(1)));

    // R9: reads while collecting leave the write count alone
    p_collect_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_COLLECT && rd_hit && !wr_hit) |=> $stable(wr_idx));

endmodule

// File: rtl/c2p_regport.sv
// Chunky-to-planar register port: one data address, eight words in,
// eight planes out, wait held on reads during conversion.
// Assumes: single-cycle bus strobes; host does not read and write together.
module c2p_regport
    import c2p_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h30,
    parameter int              CONV_LAT  = 2,
    localparam int             WORD_W    = 32,
    localparam int             PIX_W     = 8,
    localparam int             IDX_W     = $clog2(PIX_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_wait
);

    logic                    hit;
    logic                    wr_hit;
    logic                    rd_hit;
    c2p_phase_e              phase;
    logic [IDX_W-1:0]        wr_idx;
    logic [IDX_W-1:0]        rd_idx;
    logic                    slot_we;
    logic [IDX_W-1:0]        slot_idx;
    logic                    cap;
    logic [PIX_W*WORD_W-1:0] chunky;
    logic [PIX_W*WORD_W-1:0] planar;

    assign hit    = (bus_addr == DATA_ADDR);
    assign wr_hit = bus_wr && hit;
    assign rd_hit = bus_rd && hit;

    c2p_seq #(.DEPTH(PIX_W), .CONV_LAT(CONV_LAT)) seq_i (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .rd_hit(rd_hit),
        .phase(phase), .wr_idx(wr_idx), .rd_idx(rd_idx),
        .slot_we(slot_we), .slot_idx(slot_idx), .cap(cap)
    );

    c2p_chunk_buf #(.WORD_W(WORD_W), .DEPTH(PIX_W)) buf_i (
        .clk(clk), .rst_n(rst_n), .we(slot_we), .idx(slot_idx),
        .wdata(bus_wdata), .flat(chunky)
    );

    c2p_transpose #(.WORD_W(WORD_W), .PIX_W(PIX_W)) xpose_i (
        .clk(clk), .rst_n(rst_n), .cap(cap), .chunky(chunky), .planar(planar)
    );

    // Drive read data and wait from the current phase.
    always_comb begin
        bus_wait  = rd_hit && (phase == ST_CONVERT);
        bus_rdata = '0;
        if (rd_hit && phase == ST_DRAIN)
            bus_rdata = planar[rd_idx*WORD_W +: WORD_W];
    end

    // R5: a stalled read never carries data
    p_wait_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> (bus_rdata == '0));

    // R7: the chunky words cannot change while converting
    p_convert_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_CONVERT) |=> $stable(chunky));

    // R8: other addresses never produce data or wait
    p_other_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_rdata == '0 && !bus_wait));

    // R4: planes are only presented during read-out
    p_planes_in_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata != '0) |-> (phase == ST_DRAIN));

endmodule

// File: tb/c2p_regport_tb.sv
module c2p_regport_tb_top;

    localparam int        LAT  = 2;
    localparam logic [7:0] DA  = 8'h30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  b_addr = 8'h00;
    logic        b_wr = 1'b0;
    logic [31:0] b_wdata = '0;
    logic        b_rd = 1'b0;
    logic [31:0] rdata;
    logic        wait_o;

    always #10 clk = ~clk;  // 50 MHz

    c2p_regport #(.ADDR_W(8), .DATA_ADDR(DA), .CONV_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr),
        .bus_wdata(b_wdata), .bus_rd(b_rd), .bus_rdata(rdata), .bus_wait(wait_o)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    // ---------------- reference model ----------------
    int          m_ph = 0;   // 0 collect, 1 convert, 2 drain
    int          m_w = 0, m_r = 0, m_c = 0;
    logic [31:0] m_slot[8];
    logic [31:0] m_pl[8];

    function automatic void build_planes();
        for (int n = 0; n < 8; n++) begin
            m_pl[n] = '0;
            for (int k = 0; k < 32; k++)
                m_pl[n][31-k] = m_slot[k/4][24 - 8*(k%4) + n];
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_w = 0; m_r = 0; m_c = 0;
        end else begin
            bit whit, rhit;
            whit = b_wr && (b_addr == DA);
            rhit = b_rd && (b_addr == DA);
            case (m_ph)
                0: if (whit) begin
                       m_slot[m_w] = b_wdata;
                       if (m_w == 7) begin m_ph = 1; m_w = 0; m_c = LAT - 1; end
                       else m_w++;
                   end
                1: if (m_c == 0) begin build_planes(); m_ph = 2; m_r = 0; end
                   else m_c--;
                default: if (whit) begin
                       m_slot[0] = b_wdata; m_w = 1; m_ph = 0; m_r = 0;
                   end else if (rhit) begin
                       if (m_r == 7) begin m_ph = 0; m_r = 0; end
                       else m_r++;
                   end
            endcase
        end
    end

    // Compare the outputs with the model every cycle, mid low phase.
    always @(negedge clk) begin
        #5;
        if (!done) begin
            logic [31:0] e_d;
            logic        e_w;
            bit          rhit;
            rhit = b_rd && (b_addr == DA);
            e_w  = rst_n && rhit && (m_ph == 1);
            e_d  = (rst_n && rhit && m_ph == 2) ? m_pl[m_r] : 32'h0;
            if (!rst_n) begin e_w = 1'b0; e_d = 32'h0; end
            n_cmp++;
            if (rdata !== e_d || wait_o !== e_w) begin
                n_bad++;
                $display("FAIL %s: rdata=%h wait=%b expected rdata=%h wait=%b",
                         cur_req, rdata, wait_o, e_d, e_w);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input bit wr, input bit rd, input logic [7:0] a,
                         input logic [31:0] d);
        @(negedge clk);
        b_wr = wr; b_rd = rd; b_addr = a; b_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, DA, 32'h0);
    endtask

    task automatic wr_word(input logic [31:0] d);
        drive(1, 0, DA, d);
    endtask

    task automatic rd_word(output logic [31:0] d);
        for (int g = 0; g < 20; g++) begin
            drive(0, 1, DA, 32'h0);
            #5;
            if (!wait_o) break;
        end
        d = rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    logic [31:0] rv;
    logic [31:0] fr[8];

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        #5;
        chk("R1", rdata, 32'h0);
        chk("R1", {31'h0, wait_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // R2 R3 R4 R5: single pixel 17 bit 5 set, read immediately after 8th write
        cur_req = "R3";
        for (int i = 0; i < 8; i++) wr_word(i == 4 ? 32'h0020_0000 : 32'h0);
        for (int n = 0; n < 8; n++) begin
            rd_word(rv);
            chk("R3", rv, n == 5 ? 32'h0000_4000 : 32'h0);
        end
        // R4: back in collection, a read returns zero
        cur_req = "R4";
        drive(0, 1, DA, 0); #5;
        chk("R4", rdata, 32'h0);

        // R5: wait lasts exactly LAT cycles
        cur_req = "R5";
        for (int i = 0; i < 8; i++) wr_word(32'hFFFF_FFFF);
        drive(0, 1, DA, 0); #5; chk("R5", {31'h0, wait_o}, 32'h1);
        drive(0, 1, DA, 0); #5; chk("R5", {31'h0, wait_o}, 32'h1);
        drive(0, 1, DA, 0); #5; chk("R5", {31'h0, wait_o}, 32'h0);
        chk("R5", rdata, 32'hFFFF_FFFF);
        for (int n = 1; n < 8; n++) rd_word(rv);

        // R2 R3: pixel k = k
        cur_req = "R2";
        for (int i = 0; i < 8; i++)
            wr_word({8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)});
        idle(3);
        rd_word(rv); chk("R2", rv, 32'h5555_5555);
        rd_word(rv); chk("R2", rv, 32'h3333_3333);
        for (int n = 2; n < 8; n++) rd_word(rv);

        // R8 R9: stray accesses and reads mid-collection
        cur_req = "R8";
        for (int i = 0; i < 3; i++) wr_word(32'h0);
        drive(1, 0, 8'h34, 32'hFFFF_FFFF);
        drive(0, 1, 8'h34, 0); #5; chk("R8", rdata, 32'h0);
        cur_req = "R9";
        drive(0, 1, DA, 0); #5; chk("R9", rdata, 32'h0);
        cur_req = "R8";
        for (int i = 3; i < 8; i++) wr_word(i == 7 ? 32'h0000_0001 : 32'h0);
        // R7: writes during conversion are dropped
        cur_req = "R7";
        wr_word(32'hFFFF_FFFF);
        wr_word(32'hFFFF_FFFF);
        for (int n = 0; n < 8; n++) begin
            rd_word(rv);
            chk("R7", rv, n == 0 ? 32'h0000_0001 : 32'h0);
        end

        // R6: abort read-out after three planes
        cur_req = "R6";
        for (int i = 0; i < 8; i++) wr_word(32'hA5A5_A5A5);
        idle(3);
        for (int n = 0; n < 3; n++) rd_word(rv);
        wr_word(32'h8000_0000);
        for (int i = 1; i < 8; i++) wr_word(32'h0);
        idle(3);
        for (int n = 0; n < 8; n++) begin
            rd_word(rv);
            chk("R6", rv, n == 7 ? 32'h8000_0000 : 32'h0);
        end

        // R10: reset mid-group
        cur_req = "R10";
        for (int i = 0; i < 5; i++) wr_word(32'hFFFF_FFFF);
        @(negedge clk); rst_n = 1'b0; b_wr = 0; b_rd = 0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 8; i++) wr_word(i == 0 ? 32'h0100_0000 : 32'h0);
        idle(3);
        for (int n = 0; n < 8; n++) begin
            rd_word(rv);
            chk("R10", rv, n == 0 ? 32'h8000_0000 : 32'h0);
        end

        // Random groups, model comparison only
        cur_req = "R3";
        for (int g = 0; g < 20; g++) begin
            for (int i = 0; i < 8; i++) wr_word($urandom);
            idle(g % 3);
            for (int n = 0; n < 8; n++) rd_word(rv);
        end
        idle(2);
        finish_run();
    end

endmodule